// File: doc/BRIEF.md
# SPI Control-Register Target

This block is a four-wire serial target that gives an external controller read and write access to a small bank of eight-bit configuration registers. It shares the bank with a second control interface. A select input picks which interface owns the bank, and this one responds only while that input is low. The bank contents are exported as a flat vector so that the rest of the chip can use them.

The serial pins are not treated as a clock. They are brought into the system clock domain through synchronizers, and the block reacts to the edges it detects there. A transaction opens when chip select falls. The first byte is a command: bit 5 chooses read or write, and bits 3..0 name the register. Each later byte is data for, or data from, the next register. The address stops rising at the top of the address space. Register 0 has no storage. Writing it returns the whole bank to its reset values, and that byte's content is thrown away.

Top module: `spi_regbank_target`

## Requirements
- R1: After the synchronous reset `rst`, every bank register reads as 0x00 on `cfg_regs` and `spi_miso_oe` is low.
- R2: The command byte is shifted in MSB first on rising SCLK edges. Bit 5 = 1 selects a read and bit 5 = 0 selects a write. Bits 3..0 are the register address. Bits 7, 6 and 4 have no effect.
- R3: In a write, the byte that follows the command is shifted in MSB first and stored in the addressed register, which is register n at `cfg_regs[(n-1)*8 +: 8]` for n = 1..10. No register changes except through a completed data byte or a bank reset.
- R4: While chip select stays low, each further write byte goes to the address after the previous one.
- R5: The address stops rising at 0x0F and does not wrap. Addresses 0x0B to 0x0F have no storage: writes to them are discarded and reads from them return 0x00.
- R6: In a read, the addressed register is driven on `spi_miso` MSB first. Each bit changes only after a falling SCLK edge, so the controller samples it at the next falling edge. Bytes on `spi_mosi` during read data are ignored.
- R7: While chip select stays low, each further read byte comes from the address after the previous one.
- R8: `spi_miso_oe` is high only from the first read-data bit until chip select rises. It stays low during the command byte, during writes, and while idle.
- R9: A write to address 0x00 returns every register to 0x00. The data byte of that write is discarded, and the next byte in the same burst goes to register 1.
- R10: A byte cut short by chip select rising is not written, and the next transaction starts again with a fresh command byte.
- R11: While `alt_if_sel` is high, serial activity writes no register and `spi_miso_oe` stays low.
- R12: A read of address 0x00 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| alt_if_sel | input | 1 | High: the other control interface owns the bank |
| spi_sclk | input | 1 | Serial clock from the controller |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial read data |
| spi_miso_oe | output | 1 | Output enable for the read-data pad; low means high impedance |
| cfg_regs | output | 80 | Registers 1..10, register n in bits (n-1)*8 +: 8 |

## Verification
Every pin change passes through two synchronizer flops and one edge-detect flop. A register write, a bank reset and each new `spi_miso` bit therefore appear three clock cycles after the SCLK edge that causes them. The bench holds each SCLK phase for eight clock cycles, so this latency always fits inside one phase. It drives inputs and samples outputs on the falling clock edge. It reads a read-data bit at the end of the high phase, just before it drives the falling edge that would replace that bit. It checks `cfg_regs` only after chip select has been high for thirty-two cycles.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;
  typedef enum logic {
    DIR_WRITE = 1'b0,
    DIR_READ  = 1'b1
  } xfer_dir_e;
endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk) begin
    if (rst) pipe_q <= {STAGES{RST_VAL}};
    else     pipe_q <= {pipe_q[STAGES-2:0], din};
  end

  assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/spi_rb_frame.sv
module spi_rb_frame
  import spi_rb_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter int RW_BIT = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              mosi,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] addr_q,
  output logic              cmd_done,
  output logic              wr_en,
  output logic              soft_rst,
  output logic [DATA_W-1:0] wr_data,
  output logic              miso,
  output logic              miso_oe
);
  localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(DATA_W - 1);
  localparam logic [ADDR_W-1:0] ADDR_TOP = '1;

  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] shift_q;
  logic [DATA_W-1:0] tx_q;
  logic [DATA_W-1:0] byte_in;
  xfer_dir_e         dir_q;
  logic              byte_end;

  assign byte_in  = {shift_q[DATA_W-2:0], mosi};
  assign byte_end = active && sclk_rise && (bit_cnt == LAST_BIT);
  assign wr_data  = byte_in;
  assign wr_en    = byte_end && cmd_done && (dir_q == DIR_WRITE) && (addr_q != '0);
  assign soft_rst = byte_end && cmd_done && (dir_q == DIR_WRITE) && (addr_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt  <= '0;
      shift_q  <= '0;
      tx_q     <= '0;
      dir_q    <= DIR_WRITE;
      addr_q   <= '0;
      cmd_done <= 1'b0;
      miso     <= 1'b0;
      miso_oe  <= 1'b0;
    end else if (!active) begin
      bit_cnt  <= '0;
      cmd_done <= 1'b0;
      miso_oe  <= 1'b0;
    end else begin
      if (sclk_rise) begin
        shift_q <= byte_in;
        bit_cnt <= byte_end ? '0 : bit_cnt + 1'b1;
        if (byte_end) begin
          if (!cmd_done) begin
            cmd_done <= 1'b1;
            dir_q    <= xfer_dir_e'(byte_in[RW_BIT]);
            addr_q   <= byte_in[ADDR_W-1:0];
          end else if (addr_q != ADDR_TOP) begin
            addr_q <= addr_q + 1'b1;
          end
        end
      end
      if (sclk_fall && cmd_done && (dir_q == DIR_READ)) begin
        if (bit_cnt == '0) begin
          tx_q    <= rd_data << 1;
          miso    <= rd_data[DATA_W-1];
          miso_oe <= 1'b1;
        end else begin
          tx_q <= tx_q << 1;
          miso <= tx_q[DATA_W-1];
        end
      end
    end
  end
endmodule

// File: rtl/spi_rb_bank.sv
module spi_rb_bank #(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 4,
  parameter int NUM_REGS = 11
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           soft_rst,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [DATA_W-1:0]              wr_data,
  output logic [DATA_W-1:0]              rd_data,
  output logic [(NUM_REGS-1)*DATA_W-1:0] cfg_q
);
  for (genvar g = 1; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst || soft_rst)
        cfg_q[(g-1)*DATA_W +: DATA_W] <= '0;
      else if (wr_en && (addr == ADDR_W'(g)))
        cfg_q[(g-1)*DATA_W +: DATA_W] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 1; i < NUM_REGS; i++)
      if (addr == ADDR_W'(i)) rd_data = cfg_q[(i-1)*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/spi_regbank_target.sv
module spi_regbank_target #(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 4,
  parameter int NUM_REGS    = 11,
  parameter int SYNC_STAGES = 2,
  parameter int RW_BIT      = 5
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           alt_if_sel,
  input  logic                           spi_sclk,
  input  logic                           spi_cs_n,
  input  logic                           spi_mosi,
  output logic                           spi_miso,
  output logic                           spi_miso_oe,
  output logic [(NUM_REGS-1)*DATA_W-1:0] cfg_regs
);
  logic sclk_sync, cs_sync, mosi_sync, sclk_prev;
  logic sclk_rise, sclk_fall, active;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] rd_data, wr_data;
  logic cmd_done, wr_en, soft_rst;

  spi_rb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
    .clk(clk), .rst(rst), .din(spi_sclk), .dout(sclk_sync));
  spi_rb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
    .clk(clk), .rst(rst), .din(spi_cs_n), .dout(cs_sync));
  spi_rb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mosi (
    .clk(clk), .rst(rst), .din(spi_mosi), .dout(mosi_sync));

  always_ff @(posedge clk) begin
    if (rst) sclk_prev <= 1'b0;
    else     sclk_prev <= sclk_sync;
  end

  assign sclk_rise = sclk_sync & ~sclk_prev;
  assign sclk_fall = ~sclk_sync & sclk_prev;
  assign active    = ~cs_sync & ~alt_if_sel;

  spi_rb_frame #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .RW_BIT(RW_BIT)) u_frame (
    .clk(clk), .rst(rst), .active(active),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .mosi(mosi_sync),
    .rd_data(rd_data), .addr_q(addr_q), .cmd_done(cmd_done),
    .wr_en(wr_en), .soft_rst(soft_rst), .wr_data(wr_data),
    .miso(spi_miso), .miso_oe(spi_miso_oe));

  spi_rb_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_bank (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .wr_en(wr_en),
    .addr(addr_q), .wr_data(wr_data), .rd_data(rd_data), .cfg_q(cfg_regs));
endmodule

// File: rtl/spi_regbank_chk.sv
module spi_regbank_chk #(
  parameter int CFG_W  = 80,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              alt_if_sel,
  input logic              cs_sync,
  input logic              sclk_fall,
  input logic              cmd_done,
  input logic              wr_en,
  input logic              soft_rst,
  input logic [ADDR_W-1:0] addr_q,
  input logic              spi_miso,
  input logic              spi_miso_oe,
  input logic [CFG_W-1:0]  cfg_regs
);
  AST_OE_OFF_IDLE: assert property (@(posedge clk) disable iff (rst)
    (cs_sync || alt_if_sel) |=> !spi_miso_oe); // R8
  AST_OE_AFTER_CMD: assert property (@(posedge clk) disable iff (rst)
    spi_miso_oe |-> cmd_done); // R8
  AST_OTHER_IF_QUIET: assert property (@(posedge clk) disable iff (rst)
    alt_if_sel |-> (!wr_en && !soft_rst)); // R11
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !soft_rst) |=> $stable(cfg_regs)); // R3
  AST_BANK_CLEAR: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (cfg_regs == '0)); // R9
  AST_ADDR_SAT: assert property (@(posedge clk) disable iff (rst)
    (cmd_done && (addr_q == '1)) |=> (addr_q == '1)); // R5
  AST_MISO_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !sclk_fall |=> $stable(spi_miso)); // R6
endmodule

bind spi_regbank_target spi_regbank_chk #(
  .CFG_W((NUM_REGS-1)*DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .alt_if_sel(alt_if_sel), .cs_sync(cs_sync),
  .sclk_fall(sclk_fall), .cmd_done(cmd_done), .wr_en(wr_en),
  .soft_rst(soft_rst), .addr_q(addr_q), .spi_miso(spi_miso),
  .spi_miso_oe(spi_miso_oe), .cfg_regs(cfg_regs)
);

// File: tb/spi_regbank_target_test.sv
module spi_regbank_target_test;
  localparam int HALF = 8;
  localparam int NREG = 11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic alt_if_sel = 1'b0;
  logic spi_sclk = 1'b0;
  logic spi_cs_n = 1'b1;
  logic spi_mosi = 1'b0;
  logic spi_miso, spi_miso_oe;
  logic [(NREG-1)*8-1:0] cfg_regs;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [7:0] exp_reg [1:NREG-1];

  always #10 clk = ~clk;

  spi_regbank_target uut (
    .clk(clk), .rst(rst), .alt_if_sel(alt_if_sel), .spi_sclk(spi_sclk),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_miso_oe(spi_miso_oe), .cfg_regs(cfg_regs));

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_open();
    spi_cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic cs_close();
    wait_clk(HALF);
    spi_cs_n = 1'b1;
    wait_clk(4 * HALF);
  endtask

  // one byte, MSB first; rx bit sampled at end of high phase
  task automatic xfer(input logic [7:0] tx, input int nbits,
                      output logic [7:0] rx, output logic oe_all, output logic oe_any);
    rx = '0; oe_all = 1'b1; oe_any = 1'b0;
    for (int i = 7; i > 7 - nbits; i--) begin
      spi_mosi = tx[i];
      wait_clk(HALF);
      spi_sclk = 1'b1;
      wait_clk(HALF);
      rx[i]  = spi_miso;
      oe_all = oe_all & spi_miso_oe;
      oe_any = oe_any | spi_miso_oe;
      spi_sclk = 1'b0;
    end
  endtask

  task automatic check_bank(input string req);
    for (int r = 1; r < NREG; r++)
      check(req, $sformatf("reg %0d", r), 32'(cfg_regs[(r-1)*8 +: 8]), 32'(exp_reg[r]));
  endtask

  initial begin
    logic [7:0] rx, cmd, val;
    logic oa, on;
    for (int r = 1; r < NREG; r++) exp_reg[r] = 8'h00;
    wait_clk(5);
    rst = 1'b0;
    wait_clk(2);
    check_bank("R1");
    check("R1", "oe after reset", 32'(spi_miso_oe), 32'd0);

    // sweep single writes; don't-care bits 7,6,4 varied (R2, R3)
    for (int r = 1; r < NREG; r++) begin
      val = 8'((r * 37 + 5) & 8'hFF);
      cmd = {r[0], r[1], 1'b0, r[2], 4'(r)};
      cs_open();
      xfer(cmd, 8, rx, oa, on);
      check("R8", "oe during write cmd", 32'(on), 32'd0);
      xfer(val, 8, rx, oa, on);
      check("R8", "oe during write data", 32'(on), 32'd0);
      cs_close();
      exp_reg[r] = val;
      check("R3", $sformatf("single write reg %0d", r), 32'(cfg_regs[(r-1)*8 +: 8]), 32'(val));
    end
    check_bank("R2");

    // sweep single reads with dummy MOSI bytes (R6, R8, R2)
    for (int r = 1; r < NREG; r++) begin
      cmd = {r[1], r[0], 1'b1, r[3], 4'(r)};
      cs_open();
      xfer(cmd, 8, rx, oa, on);
      check("R8", "oe during read cmd", 32'(on), 32'd0);
      xfer(8'hA5 ^ 8'(r), 8, rx, oa, on);
      check("R6", $sformatf("read reg %0d", r), 32'(rx), 32'(exp_reg[r]));
      check("R8", "oe during read data", 32'(oa), 32'd1);
      cs_close();
      check("R8", "oe after cs rise", 32'(spi_miso_oe), 32'd0);
    end
    check_bank("R6");

    // burst write from reg 1 (R4)
    cs_open();
    xfer(8'h01, 8, rx, oa, on);
    for (int r = 1; r < NREG; r++) begin
      val = 8'((r * 91 + 17) & 8'hFF);
      xfer(val, 8, rx, oa, on);
      exp_reg[r] = val;
    end
    cs_close();
    check_bank("R4");

    // burst read from reg 1 running past the top of storage (R7, R5)
    cs_open();
    xfer(8'h21, 8, rx, oa, on);
    for (int r = 1; r < NREG + 2; r++) begin
      xfer(8'hFF, 8, rx, oa, on);
      if (r < NREG) check("R7", $sformatf("burst read reg %0d", r), 32'(rx), 32'(exp_reg[r]));
      else          check("R5", $sformatf("read unmapped 0x%0h", r), 32'(rx), 32'd0);
    end
    cs_close();

    // read of address 0 (R12)
    cs_open();
    xfer(8'h20, 8, rx, oa, on);
    xfer(8'h00, 8, rx, oa, on);
    check("R12", "read addr 0", 32'(rx), 32'd0);
    cs_close();

    // burst write from 0x0C: saturates at 0x0F, no wrap into reset or reg 1 (R5)
    cs_open();
    xfer(8'h0C, 8, rx, oa, on);
    for (int k = 0; k < 6; k++) xfer(8'hC3, 8, rx, oa, on);
    cs_close();
    check_bank("R5");

    // truncated byte (R10)
    cs_open();
    xfer(8'h03, 8, rx, oa, on);
    xfer(8'hEE, 4, rx, oa, on);
    cs_close();
    check("R10", "partial byte", 32'(cfg_regs[2*8 +: 8]), 32'(exp_reg[3]));
    cs_open();
    xfer(8'h03, 8, rx, oa, on);
    xfer(8'h6B, 8, rx, oa, on);
    cs_close();
    exp_reg[3] = 8'h6B;
    check("R10", "fresh transfer after abort", 32'(cfg_regs[2*8 +: 8]), 32'h6B);

    // reset through address 0, then burst continues at reg 1 (R9)
    cs_open();
    xfer(8'h00, 8, rx, oa, on);
    xfer(8'hFF, 8, rx, oa, on);
    xfer(8'h5A, 8, rx, oa, on);
    xfer(8'h3C, 8, rx, oa, on);
    cs_close();
    for (int r = 1; r < NREG; r++) exp_reg[r] = 8'h00;
    exp_reg[1] = 8'h5A;
    exp_reg[2] = 8'h3C;
    check_bank("R9");

    // other interface owns the bank (R11)
    alt_if_sel = 1'b1;
    cs_open();
    xfer(8'h04, 8, rx, oa, on);
    xfer(8'h77, 8, rx, oa, on);
    cs_close();
    check("R11", "write ignored", 32'(cfg_regs[3*8 +: 8]), 32'(exp_reg[4]));
    cs_open();
    xfer(8'h21, 8, rx, oa, on);
    xfer(8'h00, 8, rx, oa, on);
    check("R11", "oe held low", 32'(on), 32'd0);
    cs_close();
    alt_if_sel = 1'b0;
    check_bank("R11");

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule